// File: doc/BRIEF.md
# Frame-Aligned Slip Buffer

This block is an elastic store for channelised T1 traffic. A producer pushes channel bytes in, one byte per enabled cycle, and flags the first byte of every frame. A consumer pulls bytes out at its own average rate. The two rates are skewed by enables on a shared clock. The store holds two frames. When the producer gets too far ahead or too far behind, the block corrects by exactly one frame, so frame alignment survives on both sides.

The decisions are taken only at frame boundaries.

- **Deletion:** when a producer frame begins and the free space is less than one frame, that whole incoming frame is discarded.
- **Repetition:** when a consumer frame begins and less than one frame is stored, the frame most recently delivered is delivered again from its first byte.

Three sticky status bits record these slips. They stay set until a host read strobe or a write-one-to-clear access removes them.

Top module: `frame_slip_buffer`

## Requirements
- R1: When `wr_en` and `wr_fs` are high in a cycle where fewer than FRAME_LEN (24) slots are free, none of the bytes of that producer frame is ever delivered. The next delivered frame after the older stored ones is the next accepted producer frame.
- R2: When `rd_en` is high on the first byte of a consumer frame and fewer than FRAME_LEN bytes are stored, the consumer receives, in order, the same FRAME_LEN bytes it received in its previous frame.
- R3: Otherwise bytes leave in the order they were accepted. `rd_valid` and `rd_data` appear in the cycle after `rd_en`. `rd_sof` is high with the first byte of each consumer frame.
- R4: Status bit 7 becomes 1 in the cycle after a deletion and bit 6 in the cycle after a repetition. Neither bit is set by the other event, and bits 4:0 always read 0.
- R5: Status bit 5 becomes 1 in the cycle after either a deletion or a repetition.
- R6: A cycle with `stat_rd` high clears status bits 7:5 from the next cycle on. A bit whose event occurs in that same cycle still reads 1.
- R7: A cycle with `stat_wr` high clears each status bit whose `stat_clr` bit is 1: `stat_clr[2]` maps to bit 7, `stat_clr[1]` to bit 6 and `stat_clr[0]` to bit 5. A bit whose event occurs in the same cycle still reads 1.
- R8: After reset the status reads 0, `rd_valid` is 0 and the store is empty, so the first producer frame is accepted.
- R9: Bytes written after reset and before the first `wr_fs` marker are discarded, and they raise no status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both sides |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Producer byte strobe |
| wr_fs | input | 1 | Marks the producer byte as the first of a frame |
| wr_data | input | DATA_W | Producer byte |
| rd_en | input | 1 | Consumer byte request |
| rd_valid | output | 1 | Delivered byte is present (one cycle after `rd_en`) |
| rd_data | output | DATA_W | Delivered byte |
| rd_sof | output | 1 | Delivered byte is the first of a consumer frame |
| stat_rd | input | 1 | Host read strobe of the status word |
| stat_wr | input | 1 | Host write strobe, write-one-to-clear |
| stat_clr | input | 3 | Clear mask for bits 7, 6, 5 (MSB first) |
| status | output | 8 | Sticky status: bit 7 deletion, bit 6 repetition, bit 5 any slip |

## Verification
The assertions assume that the producer supplies exactly FRAME_LEN bytes after every `wr_fs` marker. They also assume that the consumer always requests whole frames, because occupancy is only checked at frame boundaries. The stimulus derives `wr_fs` and the byte index from a frame counter in the bench, so no frame is ever short or long. Until the first marker, the bench sends only unmarked bytes. Rate skew comes from random enables at fixed probabilities, which push the store alternately into overflow and underflow.

// File: rtl/fslip_pkg.sv
package fslip_pkg;
  localparam int unsigned STAT_DEL_BIT  = 7;
  localparam int unsigned STAT_REP_BIT  = 6;
  localparam int unsigned STAT_SLIP_BIT = 5;

  typedef struct packed {
    logic del;
    logic rep;
  } slip_ev_t;
endpackage

// File: rtl/fslip_ram.sv
module fslip_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 48,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fslip_wr_ctrl.sv
module fslip_wr_ctrl #(
  parameter int FRAME_LEN = 24,
  parameter int DEPTH     = 48,
  parameter int AW        = 6,
  parameter int CW        = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_fs,
  input  logic [CW-1:0] fill,
  output logic          wr_accept,
  output logic [AW-1:0] wr_addr,
  output logic          del_evt
);
  logic          drop_q;
  logic          drop_now;
  logic          frame_start;
  logic          no_room;
  logic [AW-1:0] wp_q;

  assign frame_start = wr_en & wr_fs;
  assign no_room     = (CW'(DEPTH) - fill) < CW'(FRAME_LEN);
  assign del_evt     = frame_start & no_room;
  assign drop_now    = frame_start ? no_room : drop_q;
  assign wr_accept   = wr_en & ~drop_now;
  assign wr_addr     = wp_q;

  // Unaligned bytes (R9) are dropped until the first marker decides a frame
  always_ff @(posedge clk) begin
    if (rst) begin
      drop_q <= 1'b1;
      wp_q   <= '0;
    end else begin
      if (frame_start) drop_q <= no_room;
      if (wr_accept) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    end
  end
endmodule

// File: rtl/fslip_rd_ctrl.sv
module fslip_rd_ctrl #(
  parameter int FRAME_LEN = 24,
  parameter int DEPTH     = 48,
  parameter int AW        = 6,
  parameter int CW        = 6,
  parameter int PW        = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [CW-1:0] fill,
  output logic [AW-1:0] rd_addr,
  output logic          rd_first,
  output logic          rep_evt
);
  logic [AW-1:0] rp_q;
  logic [AW-1:0] rp_back;
  logic [PW-1:0] pos_q;
  logic          at_start;

  assign at_start = (pos_q == '0);
  assign rd_first = rd_en & at_start;
  assign rep_evt  = rd_first & (fill < CW'(FRAME_LEN));
  assign rp_back  = (rp_q >= AW'(FRAME_LEN)) ? rp_q - AW'(FRAME_LEN)
                                             : rp_q + AW'(DEPTH - FRAME_LEN);
  // R2: a starved frame start replays from one frame earlier
  assign rd_addr  = rep_evt ? rp_back : rp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rp_q  <= '0;
      pos_q <= '0;
    end else if (rd_en) begin
      rp_q  <= (rd_addr == AW'(DEPTH - 1)) ? '0 : rd_addr + 1'b1;
      pos_q <= (pos_q == PW'(FRAME_LEN - 1)) ? '0 : pos_q + 1'b1;
    end
  end
endmodule

// File: rtl/fslip_status.sv
module fslip_status
  import fslip_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  slip_ev_t       ev,
  input  logic           host_rd,
  input  logic           host_wr,
  input  logic [2:0]     host_clr,
  output logic [2:0]     sticky
);
  logic [2:0] keep;
  logic [2:0] set;

  always_comb begin
    keep = sticky;
    if (host_rd) keep = 3'b000;
    if (host_wr) keep = keep & ~host_clr;
    set  = {ev.del, ev.rep, ev.del | ev.rep};
  end

  // R6/R7: an event in the clearing cycle wins
  always_ff @(posedge clk) begin
    if (rst) sticky <= 3'b000;
    else     sticky <= keep | set;
  end
endmodule

// File: rtl/frame_slip_buffer.sv
module frame_slip_buffer
  import fslip_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int FRAME_LEN = 24,
  parameter int FRAMES    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_fs,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_sof,
  input  logic              stat_rd,
  input  logic              stat_wr,
  input  logic [2:0]        stat_clr,
  output logic [7:0]        status
);
  localparam int DEPTH = FRAME_LEN * FRAMES;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int PW    = $clog2(FRAME_LEN);

  logic          wr_accept;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;
  logic          rd_first;
  logic          del_evt;
  logic          rep_evt;
  logic [CW-1:0] fill_q;
  logic [CW-1:0] fill_add;
  logic [2:0]    sticky;
  slip_ev_t      ev;

  fslip_wr_ctrl #(.FRAME_LEN(FRAME_LEN), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_wr (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_fs(wr_fs), .fill(fill_q),
    .wr_accept(wr_accept), .wr_addr(wr_addr), .del_evt(del_evt));

  fslip_rd_ctrl #(.FRAME_LEN(FRAME_LEN), .DEPTH(DEPTH), .AW(AW), .CW(CW), .PW(PW)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .fill(fill_q),
    .rd_addr(rd_addr), .rd_first(rd_first), .rep_evt(rep_evt));

  fslip_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(wr_accept), .waddr(wr_addr), .wdata(wr_data),
    .re(rd_en), .raddr(rd_addr), .rdata(rd_data));

  assign ev.del = del_evt;
  assign ev.rep = rep_evt;

  fslip_status u_stat (
    .clk(clk), .rst(rst), .ev(ev), .host_rd(stat_rd), .host_wr(stat_wr),
    .host_clr(stat_clr), .sticky(sticky));

  // A repetition makes one frame of already-read bytes unread again
  assign fill_add = rep_evt ? CW'(FRAME_LEN) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q   <= '0;
      rd_valid <= 1'b0;
      rd_sof   <= 1'b0;
    end else begin
      fill_q   <= fill_q + fill_add + CW'(wr_accept) - CW'(rd_en);
      rd_valid <= rd_en;
      rd_sof   <= rd_first;
    end
  end

  always_comb begin
    status                = 8'h00;
    status[STAT_DEL_BIT]  = sticky[2];
    status[STAT_REP_BIT]  = sticky[1];
    status[STAT_SLIP_BIT] = sticky[0];
  end
endmodule

// File: rtl/fslip_checker.sv
module fslip_checker #(
  parameter int DEPTH = 48,
  parameter int CW    = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_en,
  input logic          rd_valid,
  input logic          stat_rd,
  input logic          stat_wr,
  input logic [2:0]    stat_clr,
  input logic [7:0]    status,
  input logic [CW-1:0] fill,
  input logic          del_evt,
  input logic          rep_evt
);
  p_fill_bound_r1: assert property (@(posedge clk) disable iff (rst)
    fill <= CW'(DEPTH));

  p_del_sets_full_r4: assert property (@(posedge clk) disable iff (rst)
    del_evt |=> (status[7] && status[5]));

  p_rep_sets_empty_r2: assert property (@(posedge clk) disable iff (rst)
    rep_evt |=> (status[6] && status[5]));

  p_rise_full_slip_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(status[7]) |-> status[5]);

  p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !del_evt && !rep_evt) |=> (status[7:5] == 3'b000));

  p_sticky_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (status[7] && !stat_rd && !(stat_wr && stat_clr[2])) |=> status[7]);

  p_w1c_empty_r7: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && stat_clr[1] && !stat_rd && !rep_evt) |=> !status[6]);

  p_rd_latency_r3: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  p_no_spurious_valid_r3: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
endmodule

bind frame_slip_buffer fslip_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_valid(rd_valid),
  .stat_rd(stat_rd), .stat_wr(stat_wr), .stat_clr(stat_clr), .status(status),
  .fill(fill_q), .del_evt(del_evt), .rep_evt(rep_evt));

// File: tb/frame_slip_buffer_tb_top.sv
module frame_slip_buffer_tb_top;
  localparam int FL  = 24;
  localparam int DEP = 48;

  logic clk = 1'b0;
  logic rst;
  logic wr_en, wr_fs, rd_en, rd_valid, rd_sof, stat_rd, stat_wr;
  logic [7:0] wr_data, rd_data, status;
  logic [2:0] stat_clr;

  always #5 clk = ~clk;

  frame_slip_buffer dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_fs(wr_fs), .wr_data(wr_data),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data), .rd_sof(rd_sof),
    .stat_rd(stat_rd), .stat_wr(stat_wr), .stat_clr(stat_clr), .status(status));

  int nchk = 0, nfail = 0;
  int mfill = 0, wi = 0, wk = 0, ri = 0, last_tag = 0, cur_tag = 0;
  bit mdrop = 1, last_del = 0, junk_mode = 1;
  bit exp_v = 0, exp_s = 0, prev_srd = 0, prev_swr = 0;
  logic [7:0] exp_d = 8'h00;
  logic [2:0] stat_exp = 3'b000;
  string exp_lbl = "R3", cur_lbl = "R3";
  int fq[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic step(input bit we, input bit re, input bit srd, input bit swr,
                      input logic [2:0] clr);
    int fb, add, e;
    bit acc, ev_del, ev_rep;
    @(negedge clk);
    // outputs reflect the previous cycle's inputs
    chk("R3 rd_valid", rd_valid, exp_v);
    if (exp_v) begin
      chk({exp_lbl, " rd_data"}, rd_data, exp_d);
      chk("R3 rd_sof", rd_sof, exp_s);
    end
    chk("R4 status[7]", status[7], stat_exp[2]);
    chk("R4 status[6]", status[6], stat_exp[1]);
    chk("R5 status[5]", status[5], stat_exp[0]);
    chk("R4 status[4:0]", status[4:0], 0);
    if (prev_srd) chk("R6 status after read", status[7:5], stat_exp);
    if (prev_swr) chk("R7 status after clear", status[7:5], stat_exp);

    wr_en = we; rd_en = re; stat_rd = srd; stat_wr = swr; stat_clr = clr;
    wr_fs = 1'b0; wr_data = 8'hFF;
    fb = mfill; add = 0; acc = 0; ev_del = 0; ev_rep = 0;
    if (we && !junk_mode) begin
      wr_fs = (wi == 0);
      wr_data = {wk[2:0], wi[4:0]};
      if (wi == 0) begin
        mdrop = (DEP - fb) < FL;
        if (mdrop) begin ev_del = 1; last_del = 1; end
        else begin fq.push_back(wk + (last_del ? 256 : 0)); last_del = 0; end
      end
      acc = !mdrop;
      wi++;
      if (wi == FL) begin wi = 0; wk++; end
    end
    if (re) begin
      if (ri == 0) begin
        if (fb < FL) begin
          ev_rep = 1; cur_tag = last_tag; cur_lbl = "R2"; add = FL;
        end else begin
          e = fq.pop_front();
          cur_tag = e % 256;
          cur_lbl = (e >= 256) ? "R1" : "R3";
          last_tag = cur_tag;
        end
      end
      exp_d = {cur_tag[2:0], ri[4:0]};
      exp_s = (ri == 0);
      exp_lbl = cur_lbl;
      ri++;
      if (ri == FL) ri = 0;
    end
    exp_v = re;
    mfill = fb + add + (acc ? 1 : 0) - (re ? 1 : 0);
    if (srd) stat_exp = 3'b000;
    if (swr) stat_exp = stat_exp & ~clr;
    stat_exp = stat_exp | {ev_del, ev_rep, ev_del | ev_rep};
    prev_srd = srd; prev_swr = swr;
  endtask

  task automatic run_rand(input int cycles, input int pw, input int pr);
    for (int c = 0; c < cycles; c++) begin
      bit srd, swr;
      srd = ($urandom % 100) < 2;
      swr = ($urandom % 100) < 2;
      step(($urandom % 100) < pw, ($urandom % 100) < pr, srd, swr,
           3'($urandom % 8));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst = 1; wr_en = 0; wr_fs = 0; wr_data = 0; rd_en = 0;
    stat_rd = 0; stat_wr = 0; stat_clr = 0;
    repeat (4) @(posedge clk);
    rst = 0;
    @(negedge clk);
    chk("R8 reset status", status, 0);
    chk("R8 reset rd_valid", rd_valid, 0);
    // R9: unmarked bytes before the first marker
    for (int j = 0; j < 5; j++) step(1, 0, 0, 0, 3'b000);
    junk_mode = 0;
    step(0, 0, 0, 0, 3'b000);
    chk("R9 no status from unaligned bytes", status, 0);
    // two frames fill the store, the third is deleted with a same-cycle read
    for (int j = 0; j < 3 * FL; j++)
      step(1, 0, (wk == 2 && wi == 0), 0, 3'b000);
    step(0, 0, 0, 0, 3'b000);
    chk("R6 event survives same-cycle read", status[7:5], 3'b101);
    run_rand(400, 100, 85);
    run_rand(600, 75, 100);
    run_rand(400, 95, 95);
    // R7 directed: clear only the repetition bit
    step(0, 0, 0, 1, 3'b010);
    step(0, 0, 0, 0, 3'b000);
    chk("R7 directed w1c bit6", status[6], 0);
    step(0, 0, 1, 0, 3'b000);
    step(0, 0, 0, 0, 3'b000);
    chk("R6 directed read clear", status[7:5], 3'b000);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule